// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in bit. It returns a 16-bit sum and a carry-out. It is purely combinational, with no clock and no reset, so its outputs follow its inputs within the same cycle. It is meant to sit in a datapath where the carry chain would otherwise set the cycle time.

The operand width is divided into four slices of four bits each. Inside a slice, every bit forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). A flat lookahead network turns these terms and the slice carry-in into the slice's internal carries, its sum bits, and a group generate and group propagate pair. A second lookahead unit of the same form takes the four group pairs and the block carry-in. It produces the carries into slices 1 to 3 and the final carry-out, so no carry ripples from one slice to the next.

The group generate and group propagate for all 16 bits are also output. A wider adder can therefore place this block under a further lookahead level.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `a_in + b_in + carry_in`, treating both operands as unsigned.
- R2: `carry_out` equals bit 16 of `a_in + b_in + carry_in`.
- R3: `grp_gen_out` is 1 exactly when `a_in + b_in`, without the carry-in, is 65536 or more.
- R4: `grp_prop_out` is 1 exactly when every bit of `a_in XOR b_in` is 1.
- R5: When every bit propagates, `carry_out` equals `carry_in`. In that case `sum_out` is 0x0000 when `carry_in` is 1 and 0xFFFF when it is 0.
- R6: `carry_out` always equals `grp_gen_out OR (grp_prop_out AND carry_in)`.
- R7: A carry formed in a lower 4-bit slice reaches the higher slices correctly. Examples: 0x000F + 0x0001 = 0x0010, 0x0FFF + 0x0001 = 0x1000, and 0xFFFF + 0x0001 = 0x0000 with a carry-out.
- R8: The block has no state. The outputs depend only on the present inputs and are valid in the same cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_gen_out | output | 1 | Generate for the whole 16 bits |
| grp_prop_out | output | 1 | Propagate for the whole 16 bits |

## Verification
Random operand pairs from a fixed seed, with random carry-in, exercise the general sum and carry behaviour. Full-length propagate chains such as 0xFFFF + 0x0001 and 0xFFFF + 0x0000 with a carry-in separate a correct second-level lookahead from one that drops a group propagate term. Carries that cross exactly one, two or three slice boundaries show whether each second-level carry reaches the right slice. Zero operands with and without carry-in, and a sign-bit-only carry (0x8000 + 0x8000), show whether the carry-in term and the topmost generate term each reach the outputs independently.

// File: rtl/la_pkg.sv
`timescale 1ns/1ps
package la_pkg;
  // generate / propagate pair formed by one bit cell
  typedef struct packed {
    logic gen;
    logic prop;
  } pg_t;

  localparam int unsigned DEF_SLICE_W    = 4;
  localparam int unsigned DEF_NUM_SLICES = 4;
endpackage

// File: rtl/la_pg_cell.sv
`timescale 1ns/1ps
module la_pg_cell
  import la_pkg::*;
(
  input  logic bit_a,
  input  logic bit_b,
  output pg_t  pg
);
  always_comb begin
    pg.gen  = bit_a & bit_b;
    pg.prop = bit_a ^ bit_b;
  end
endmodule

// File: rtl/la_carry_unit.sv
`timescale 1ns/1ps
// Flat two-level lookahead: every carry is a sum of products of g, p and cin.
module la_carry_unit #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_in,
  input  logic [N-1:0] prop_in,
  input  logic         cin,
  output logic [N:1]   carry,
  output logic         grp_gen,
  output logic         grp_prop
);
  logic [N:1] carry_v;
  logic       grp_gen_v;

  always_comb begin
    logic acc;
    logic prod;
    for (int i = 0; i < N; i++) begin
      acc = gen_in[i];
      for (int j = 0; j < i; j++) begin
        prod = gen_in[j];
        for (int k = j + 1; k <= i; k++) prod = prod & prop_in[k];
        acc = acc | prod;
      end
      prod = cin;
      for (int k = 0; k <= i; k++) prod = prod & prop_in[k];
      carry_v[i+1] = acc | prod;
    end
  end

  // group generate: the top-carry product terms without the carry-in term
  always_comb begin
    logic acc;
    logic prod;
    acc = gen_in[N-1];
    for (int j = 0; j < N - 1; j++) begin
      prod = gen_in[j];
      for (int k = j + 1; k < N; k++) prod = prod & prop_in[k];
      acc = acc | prod;
    end
    grp_gen_v = acc;
  end

  assign carry    = carry_v;
  assign grp_gen  = grp_gen_v;
  assign grp_prop = &prop_in;

  // R6: top carry is consistent with the group pair
  always_comb begin
    a_r6_carry_from_group: assert (carry[N] == (grp_gen | (grp_prop & cin)))
      else $error("R6 top carry disagrees with group generate/propagate");
  end
endmodule

// File: rtl/la_slice.sv
`timescale 1ns/1ps
module la_slice
  import la_pkg::*;
#(
  parameter int unsigned W = DEF_SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         grp_gen,
  output logic         grp_prop
);
  pg_t        pg [W];
  logic [W-1:0] g_vec;
  logic [W-1:0] p_vec;
  logic [W:1]   c_int;
  logic [W-1:0] c_bit;

  for (genvar i = 0; i < W; i++) begin : g_bit
    la_pg_cell u_cell (
      .bit_a (a[i]),
      .bit_b (b[i]),
      .pg    (pg[i])
    );
    assign g_vec[i] = pg[i].gen;
    assign p_vec[i] = pg[i].prop;
  end

  la_carry_unit #(.N(W)) u_look (
    .gen_in   (g_vec),
    .prop_in  (p_vec),
    .cin      (cin),
    .carry    (c_int),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop)
  );

  assign c_bit = {c_int[W-1:1], cin};
  assign sum   = p_vec ^ c_bit;
  assign cout  = c_int[W];

  // R1: slice result matches an arithmetic reference
  logic [W:0] slice_ref;
  always_comb begin
    slice_ref = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    a_r1_slice_sum: assert ({cout, sum} == slice_ref)
      else $error("R1 slice sum mismatch");
  end
endmodule

// File: rtl/lookahead_adder.sv
`timescale 1ns/1ps
module lookahead_adder
  import la_pkg::*;
#(
  parameter int unsigned SLICE_W    = DEF_SLICE_W,
  parameter int unsigned NUM_SLICES = DEF_NUM_SLICES
) (
  input  logic [SLICE_W*NUM_SLICES-1:0] a_in,
  input  logic [SLICE_W*NUM_SLICES-1:0] b_in,
  input  logic                          carry_in,
  output logic [SLICE_W*NUM_SLICES-1:0] sum_out,
  output logic                          carry_out,
  output logic                          grp_gen_out,
  output logic                          grp_prop_out
);
  localparam int unsigned WIDTH = SLICE_W * NUM_SLICES;

  logic [NUM_SLICES-1:0] slice_g;
  logic [NUM_SLICES-1:0] slice_p;
  logic [NUM_SLICES-1:0] slice_co;
  logic [NUM_SLICES-1:0] slice_ci;
  logic [NUM_SLICES:1]   lvl2_carry;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    if (k == 0) begin : g_first
      assign slice_ci[k] = carry_in;
    end else begin : g_rest
      assign slice_ci[k] = lvl2_carry[k];
    end
    la_slice #(.W(SLICE_W)) u_slice (
      .a        (a_in[k*SLICE_W +: SLICE_W]),
      .b        (b_in[k*SLICE_W +: SLICE_W]),
      .cin      (slice_ci[k]),
      .sum      (sum_out[k*SLICE_W +: SLICE_W]),
      .cout     (slice_co[k]),
      .grp_gen  (slice_g[k]),
      .grp_prop (slice_p[k])
    );
  end

  la_carry_unit #(.N(NUM_SLICES)) u_lvl2 (
    .gen_in   (slice_g),
    .prop_in  (slice_p),
    .cin      (carry_in),
    .carry    (lvl2_carry),
    .grp_gen  (grp_gen_out),
    .grp_prop (grp_prop_out)
  );

  assign carry_out = lvl2_carry[NUM_SLICES];

  logic [WIDTH:0] full_ref;
  logic [WIDTH:0] nocin_ref;
  always_comb begin
    full_ref  = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in};
    nocin_ref = {1'b0, a_in} + {1'b0, b_in};
    a_r2_full_sum: assert ({carry_out, sum_out} == full_ref)
      else $error("R2 full sum mismatch");
    a_r3_group_gen: assert (grp_gen_out == nocin_ref[WIDTH])
      else $error("R3 group generate mismatch");
    a_r4_group_prop: assert (grp_prop_out == (&(a_in ^ b_in)))
      else $error("R4 group propagate mismatch");
    for (int k = 0; k < NUM_SLICES; k++) begin
      a_r7_slice_carry: assert (slice_co[k] == lvl2_carry[k+1])
        else $error("R7 slice carry disagrees with second-level carry");
    end
  end
endmodule

// File: tb/lookahead_adder_bench.sv
`timescale 1ns/1ps
module lookahead_adder_bench;
  logic        clk = 1'b0;
  logic [15:0] a_in;
  logic [15:0] b_in;
  logic        carry_in;
  logic [15:0] sum_out;
  logic        carry_out;
  logic        grp_gen_out;
  logic        grp_prop_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lookahead_adder u_lookahead_adder (
    .a_in         (a_in),
    .b_in         (b_in),
    .carry_in     (carry_in),
    .sum_out      (sum_out),
    .carry_out    (carry_out),
    .grp_gen_out  (grp_gen_out),
    .grp_prop_out (grp_prop_out)
  );

  function automatic logic [16:0] exp_total(input logic [15:0] a, input logic [15:0] b,
                                            input logic c);
    int unsigned t;
    t = int'(a) + int'(b) + int'(c);
    return t[16:0];
  endfunction

  function automatic logic exp_gen(input logic [15:0] a, input logic [15:0] b);
    return (int'(a) + int'(b)) >= 65536;
  endfunction

  function automatic logic exp_prop(input logic [15:0] a, input logic [15:0] b);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 16; i++) if (a[i] == b[i]) r = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a_in, b_in,
               carry_in, got, exp);
    end
  endtask

  // drive at a rising edge, check at the following falling edge
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] t;
    @(posedge clk);
    a_in = a; b_in = b; carry_in = c;
    @(negedge clk);
    t = exp_total(a, b, c);
    check("R1 sum", {16'd0, sum_out}, {16'd0, t[15:0]});
    check("R2 carry_out", {31'd0, carry_out}, {31'd0, t[16]});
    check("R3 group generate", {31'd0, grp_gen_out}, {31'd0, exp_gen(a, b)});
    check("R4 group propagate", {31'd0, grp_prop_out}, {31'd0, exp_prop(a, b)});
    check("R6 carry relation", {31'd0, carry_out},
          {31'd0, exp_gen(a, b) | (exp_prop(a, b) & c)});
  endtask

  initial begin
    a_in = '0; b_in = '0; carry_in = 1'b0;
    void'($urandom(32'd20240611));

    // R8: idle inputs give zero outputs in the first cycle
    @(negedge clk);
    check("R8 idle sum", {16'd0, sum_out}, 32'd0);
    check("R8 idle carry", {31'd0, carry_out}, 32'd0);

    apply(16'h0000, 16'h0000, 1'b1);                 // R2: carry-in only
    check("R1 zero+cin", {16'd0, sum_out}, 32'h0001);
    apply(16'hFFFF, 16'h0001, 1'b0);                 // R7: full ripple through slices
    check("R7 ffff+1 sum", {16'd0, sum_out}, 32'h0000);
    check("R7 ffff+1 cout", {31'd0, carry_out}, 32'd1);
    apply(16'hFFFF, 16'h0000, 1'b1);                 // R5 propagate all, cin=1
    check("R5 prop cin1 sum", {16'd0, sum_out}, 32'h0000);
    check("R5 prop cin1 cout", {31'd0, carry_out}, 32'd1);
    apply(16'hA5A5, 16'h5A5A, 1'b0);                 // R5 propagate all, cin=0
    check("R5 prop cin0 sum", {16'd0, sum_out}, 32'hFFFF);
    check("R5 prop cin0 cout", {31'd0, carry_out}, 32'd0);
    apply(16'h000F, 16'h0001, 1'b0);
    check("R7 one boundary", {16'd0, sum_out}, 32'h0010);
    apply(16'h00FF, 16'h0001, 1'b0);
    check("R7 two boundaries", {16'd0, sum_out}, 32'h0100);
    apply(16'h0FFF, 16'h0001, 1'b0);
    check("R7 three boundaries", {16'd0, sum_out}, 32'h1000);
    apply(16'h8000, 16'h8000, 1'b0);
    check("R3 top generate", {31'd0, grp_gen_out}, 32'd1);
    apply(16'h00FF, 16'hFF00, 1'b1);

    for (int n = 0; n < 3000; n++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule